// File: doc/BRIEF.md
# I2C Read-Only Slave with Clock Stretching

This block is a 7-bit-address I2C slave that serves read transactions only. A fast system clock samples the SCL and SDA lines through synchronizers and detects bus edges. The block finds START and STOP conditions and collects the address byte. If the address is its own and the direction bit requests a read, it acknowledges and then holds SCL low. SCL stays low until a local host has placed a byte in the transmit buffer and then released the clock. The byte goes out MSB first. The acknowledge from the master decides what comes next: the slave either stretches again for another byte or drops back to waiting for a START.

The host side is a small set of strobes and flags. A load strobe writes the buffer and the output shift register together. A release strobe frees SCL. A sticky interrupt flag marks the end of every byte, and a clear strobe resets it. The host can also read the buffer, a read-direction flag and a buffer-full flag. Both bus outputs are open-drain enables: a 1 pulls the line low and a 0 leaves it floating.

Top module: `i2c_rd_slave`

## Requirements
- R1: After reset, scl_pull, sda_pull, stat_read, stat_full and irq are 0 and buf_out is 0.
- R2: When the received address byte carries the device address in bits 7..1 and a 1 in bit 0 (read), the slave pulls SDA low during the ninth clock, sets stat_read, and copies the whole address byte into buf_out.
- R3: An address byte with a different address, or with bit 0 equal to 0, gets no acknowledge (SDA stays high on the ninth clock), raises no irq and causes no stretching.
- R4: After the acknowledge of a matched address, or of a data byte the master acknowledged, the slave pulls SCL low from the ninth falling edge until the host releases it.
- R5: A release strobe issued in a stretch before the buffer has been loaded in that stretch is ignored, so SCL stays low.
- R6: A load strobe outside a stretch is ignored: buf_out and stat_full keep their values.
- R7: stat_full becomes 1 on a load strobe during a stretch and returns to 0 when the release strobe starts the byte.
- R8: The loaded byte is sent MSB first, and SDA changes only while SCL is low.
- R9: irq is set on the falling edge of the ninth SCL pulse of every byte and stays 1 until irq_clear is pulsed.
- R10: The slave latches the master's acknowledge on the ninth rising SCL edge. On an ACK (SDA low) it stretches SCL again for the next byte.
- R11: On a NACK (SDA high), the slave clears stat_read and stat_full, releases both lines and ignores the bus until the next START.
- R12: A STOP (SDA rising while SCL is high) in the middle of the address byte aborts it. A START (SDA falling while SCL is high), including a repeated START without a STOP, restarts address reception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (open-drain enable) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| host_load | input | 1 | Strobe: write host_data into buffer and shift register |
| host_data | input | 8 | Byte to transmit |
| host_release | input | 1 | Strobe: release the stretched SCL |
| irq_clear | input | 1 | Strobe: clear irq |
| buf_out | output | 8 | Buffer contents (address byte or loaded data) |
| stat_read | output | 1 | Read transaction in progress |
| stat_full | output | 1 | Buffer loaded, not yet started |
| irq | output | 1 | Sticky end-of-byte flag |

## Verification
The hardest situation to reach is the stretch itself. The master has already let go of SCL, yet the line must still read low, and the release strobe must be refused until a load has come first. To get there, the bench master releases SCL right after the address acknowledge and checks that the wired-AND bus still reads low. It then issues a premature release and checks again. Only after that does it load the buffer and release. The NACK path and the repeated START are reached in the same way by a bench master that drives whole bus transactions bit by bit.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_HOLD, S_TX, S_TACK
  } st_t;
endpackage

// File: rtl/i2cst_sync.sv
module i2cst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], din};
  end

  assign lvl  = pipe[STAGES-1];
  assign rise = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/i2cst_fsm.sv
module i2cst_fsm
  import i2cst_pkg::*;
#(
  parameter int          W        = 8,
  parameter logic [W-2:0] DEV_ADDR = 7'h3C,
  localparam int         CW       = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_lvl,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         sda_lvl,
  input  logic         sda_rise,
  input  logic         sda_fall,
  input  logic         host_load,
  input  logic [W-1:0] host_data,
  input  logic         host_release,
  input  logic         irq_clear,
  output logic         scl_pull,
  output logic         sda_pull,
  output logic [W-1:0] buf_out,
  output logic         stat_read,
  output logic         stat_full,
  output logic         irq
);
  st_t          st;
  logic [W-1:0] sh;
  logic [CW-1:0] cnt;
  logic         loaded, ack_q;
  logic         start_ev, stop_ev;

  assign start_ev = scl_lvl & sda_fall;
  assign stop_ev  = scl_lvl & sda_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; sh <= '0; cnt <= '0; loaded <= 1'b0; ack_q <= 1'b1;
      scl_pull <= 1'b0; sda_pull <= 1'b0; buf_out <= '0;
      stat_read <= 1'b0; stat_full <= 1'b0; irq <= 1'b0;
    end else begin
      if (irq_clear) irq <= 1'b0;
      if (start_ev || stop_ev) begin
        st <= start_ev ? S_ADDR : S_IDLE;
        cnt <= '0; loaded <= 1'b0;
        scl_pull <= 1'b0; sda_pull <= 1'b0;
        stat_read <= 1'b0; stat_full <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[W-2:0], sda_lvl};
              cnt <= cnt + 1'b1;
            end
            if (scl_fall && cnt == CW'(W)) begin
              if (sh[W-1:1] == DEV_ADDR && sh[0]) begin
                sda_pull <= 1'b1; stat_read <= 1'b1; buf_out <= sh;
                st <= S_AACK;
              end else begin
                st <= S_IDLE;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            sda_pull <= 1'b0; scl_pull <= 1'b1; irq <= 1'b1;
            loaded <= 1'b0; st <= S_HOLD;
          end
          S_HOLD: begin
            if (host_load) begin
              buf_out <= host_data; sh <= host_data;
              stat_full <= 1'b1; loaded <= 1'b1;
              sda_pull <= ~host_data[W-1];
            end else if (host_release && loaded) begin
              scl_pull <= 1'b0; stat_full <= 1'b0; cnt <= '0;
              st <= S_TX;
            end
          end
          S_TX: if (scl_fall) begin
            if (cnt == CW'(W - 1)) begin
              sda_pull <= 1'b0; st <= S_TACK;
            end else begin
              sh <= {sh[W-2:0], 1'b0};
              sda_pull <= ~sh[W-2];
              cnt <= cnt + 1'b1;
            end
          end
          S_TACK: begin
            if (scl_rise) ack_q <= sda_lvl;
            if (scl_fall) begin
              irq <= 1'b1;
              if (ack_q) begin
                stat_read <= 1'b0; stat_full <= 1'b0; st <= S_IDLE;
              end else begin
                scl_pull <= 1'b1; loaded <= 1'b0; st <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r5_release_needs_load: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && !loaded) |=> scl_pull);
  a_r9_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clear) |=> irq);
  a_r7_full_clears_on_release: assert property (@(posedge clk) disable iff (rst)
    $fell(scl_pull) |-> !stat_full);
  a_r8_sda_steady_high_scl: assert property (@(posedge clk) disable iff (rst)
    (st == S_TX && scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));
  a_r11_nack_releases: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == S_TACK && st == S_IDLE) |-> (!stat_read && !sda_pull && !scl_pull));
endmodule

// File: rtl/i2c_rd_slave.sv
module i2c_rd_slave #(
  parameter int         W           = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h3C,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_in,
  input  logic         sda_in,
  output logic         scl_pull,
  output logic         sda_pull,
  input  logic         host_load,
  input  logic [W-1:0] host_data,
  input  logic         host_release,
  input  logic         irq_clear,
  output logic [W-1:0] buf_out,
  output logic         stat_read,
  output logic         stat_full,
  output logic         irq
);
  logic [1:0] lines, lvl, rise, fall;
  assign lines = {sda_in, scl_in};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    i2cst_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .din(lines[g]),
      .lvl(lvl[g]), .rise(rise[g]), .fall(fall[g]));
  end

  i2cst_fsm #(.W(W), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst(rst),
    .scl_lvl(lvl[0]), .scl_rise(rise[0]), .scl_fall(fall[0]),
    .sda_lvl(lvl[1]), .sda_rise(rise[1]), .sda_fall(fall[1]),
    .host_load(host_load), .host_data(host_data),
    .host_release(host_release), .irq_clear(irq_clear),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .buf_out(buf_out),
    .stat_read(stat_read), .stat_full(stat_full), .irq(irq));
endmodule

// File: tb/sim_i2c_rd_slave.sv
`timescale 1ns/1ps
module sim_i2c_rd_slave;
  localparam logic [6:0] ADDR = 7'h3C;
  localparam int Q = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_pull, sda_pull, host_load = 1'b0, host_release = 1'b0, irq_clear = 1'b0;
  logic [7:0] host_data = 8'h00, buf_out;
  logic stat_read, stat_full, irq;
  logic scl_bus, sda_bus;
  logic tx_win = 1'b0, done = 1'b0;
  int errors = 0, checks = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_byte;
  event got_ev;

  assign scl_bus = ~(m_scl_low | scl_pull);
  assign sda_bus = ~(m_sda_low | sda_pull);

  always #2.5 clk = ~clk;

  i2c_rd_slave #(.DEV_ADDR(ADDR)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .host_load(host_load),
    .host_data(host_data), .host_release(host_release), .irq_clear(irq_clear),
    .buf_out(buf_out), .stat_read(stat_read), .stat_full(stat_full), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares bytes read by the master with the scoreboard (R8)
  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) chk(0, "R8 scoreboard empty", got_byte, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(got_byte == e, "R8 byte MSB first", got_byte, e);
    end
  end

  // SDA must not move while SCL is high during slave data bits (R8)
  always @(sda_bus) if (tx_win && scl_bus && !done)
    chk(0, "R8 SDA changed while SCL high", sda_bus, !sda_bus);

  task automatic host_pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    host_data = d;
    if (which == 0) host_load = 1'b1;
    else if (which == 1) host_release = 1'b1;
    else irq_clear = 1'b1;
    @(negedge clk);
    host_load = 1'b0; host_release = 1'b0; irq_clear = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic host_send(input logic [7:0] d);
    exp_q.push_back(d);
    host_pulse(0, d);
  endtask

  task automatic bus_start;
    m_sda_low = 1'b0; #Q; m_scl_low = 1'b0; #Q;
    m_sda_low = 1'b1; #Q; m_scl_low = 1'b1; #Q;
  endtask

  task automatic bus_stop;
    m_sda_low = 1'b1; #Q; m_scl_low = 1'b0; #Q; m_sda_low = 1'b0; #Q;
  endtask

  task automatic clk_pulse(output logic b);
    m_scl_low = 1'b0;
    wait (scl_bus == 1'b1);
    #(Q/2); b = sda_bus; #(Q/2);
    m_scl_low = 1'b1; #Q;
  endtask

  task automatic wr_bit(input logic v);
    logic d;
    m_sda_low = !v; #Q;
    clk_pulse(d);
  endtask

  task automatic wr_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) wr_bit(v[i]);
    m_sda_low = 1'b0; #Q;
    clk_pulse(ack);
  endtask

  task automatic rd_byte(input bit give_ack);
    logic [7:0] v;
    logic d;
    m_sda_low = 1'b0;
    tx_win = 1'b1;
    for (int i = 7; i >= 0; i--) begin clk_pulse(d); v[i] = d; end
    tx_win = 1'b0;
    m_sda_low = give_ack; #Q;
    clk_pulse(d);
    m_sda_low = 1'b0;
    got_byte = v;
    -> got_ev;
    #1;
  endtask

  initial begin
    logic ack;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!scl_pull && !sda_pull, "R1 bus released", {scl_pull, sda_pull}, 0);
    chk(!stat_read && !stat_full && !irq, "R1 flags clear", {stat_read, stat_full, irq}, 0);
    chk(buf_out == 8'h00, "R1 buffer", buf_out, 0);

    host_pulse(0, 8'hEE);
    chk(buf_out == 8'h00 && !stat_full, "R6 load while idle ignored", buf_out, 0);

    // read with matching address
    bus_start;
    wr_byte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R2 address ACK", ack, 0);
    chk(stat_read, "R2 read flag", stat_read, 1);
    chk(buf_out == {ADDR, 1'b1}, "R2 address in buffer", buf_out, {ADDR, 1'b1});
    chk(irq, "R9 irq after address", irq, 1);
    m_scl_low = 1'b0; #Q;
    chk(scl_bus == 1'b0, "R4 SCL stretched", scl_bus, 0);
    host_pulse(1, 8'h00); #Q;
    chk(scl_bus == 1'b0, "R5 early release ignored", scl_bus, 0);
    host_pulse(2, 8'h00);
    chk(!irq, "R9 irq cleared", irq, 0);
    m_scl_low = 1'b1; #Q;
    host_send(8'hA5);
    chk(stat_full, "R7 full after load", stat_full, 1);
    host_pulse(1, 8'h00);
    chk(!stat_full, "R7 full cleared on release", stat_full, 0);
    chk(!scl_pull, "R4 SCL released after load and release", scl_pull, 0);
    rd_byte(1'b1);
    chk(scl_pull, "R10 stretch after master ACK", scl_pull, 1);
    chk(irq, "R9 irq after data byte", irq, 1);
    host_pulse(2, 8'h00);
    host_send(8'h3C);
    host_pulse(1, 8'h00);
    rd_byte(1'b0);
    chk(!stat_read && !stat_full, "R11 status reset on NACK", {stat_read, stat_full}, 0);
    chk(!scl_pull && !sda_pull, "R11 lines released on NACK", {scl_pull, sda_pull}, 0);
    chk(irq, "R9 irq on NACK byte", irq, 1);
    host_pulse(0, 8'h77);
    chk(buf_out == 8'h3C, "R6 load after NACK ignored", buf_out, 8'h3C);
    host_pulse(2, 8'h00);
    bus_stop;

    // wrong address
    bus_start;
    wr_byte({ADDR ^ 7'h01, 1'b1}, ack);
    chk(ack == 1'b1, "R3 no ACK on other address", ack, 1);
    chk(!scl_pull && !irq, "R3 no stretch/irq", {scl_pull, irq}, 0);
    bus_stop;

    // own address, write direction
    bus_start;
    wr_byte({ADDR, 1'b0}, ack);
    chk(ack == 1'b1 && !stat_read, "R3 no ACK on write direction", ack, 1);
    bus_stop;

    // STOP in the middle of an address, then full read
    bus_start;
    wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b1);
    bus_stop;
    bus_start;
    wr_byte({ADDR ^ 7'h40, 1'b1}, ack);
    chk(ack == 1'b1, "R12 other address before repeated START", ack, 1);
    bus_start;
    wr_byte({ADDR, 1'b1}, ack);
    chk(ack == 1'b0, "R12 ACK after STOP and repeated START", ack, 0);
    host_pulse(2, 8'h00);
    host_send(8'h5A);
    host_pulse(1, 8'h00);
    rd_byte(1'b0);
    chk(!stat_read, "R11 idle after final NACK", stat_read, 0);
    bus_stop;

    #Q;
    done = 1'b1;
    chk(exp_q.size() == 0, "R8 all bytes read", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(500_000);
    if (!done) begin
      done = 1'b1;
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule